// File: doc/BRIEF.md
# Headset Audio Ground Orientation Detector

A plugged analog headset may put its microphone on either of the two sideband pins of the connector, with audio ground on the other. This block finds out which way round the plug sits and steers the microphone, audio ground and ground-sense switches to match. Once triggered it asks an external measurement front end for one reading per pin, pin 1 first, then pin 2. Each request carries the 4-bit current-source code. It compares the two readings with a low threshold and a high threshold and picks one of five outcomes: hold the present routing, either orientation, single-ground fallback, or no match.

While a run is in progress the left/right audio switches and the microphone, sense and ground switches are all forced off. When the run ends the left/right switches come back first. One cycle later the microphone/sense/ground group follows, with the routing that was just decided. When an orientation is found, a one-cycle interrupt pulse is issued and a sticky flag is set. The flag is cleared by a strobe.

Both measurement interfaces use valid/ready. The request (`meas_cmd_valid_o`) is held with its pin index and code unchanged until the front end raises `meas_cmd_ready_i`. The block raises `meas_res_ready_o` only while it waits for the reading of the pin it last requested, so a reading offered at any other time stays pending and is not taken. The front end may stall either side for any number of cycles.

Top module: `hsdet_top`

## Requirements
- R1: A run starts only on a cycle with `start_i` high, `det_en_i` high, all three of `req_right_i`, `req_left_i` and `req_agnd_i` high, and the block idle. Otherwise `busy_o` and `meas_cmd_valid_o` stay low.
- R2: A start attempt that meets R1 but has `isrc_code_i` equal to 0000 does not start a run and sets `err_o`. `err_o` is cleared when a run next starts.
- R3: A run makes two measurement requests, first with `meas_cmd_pin_o`=0 (pin 1), then with 1 (pin 2). `meas_cmd_isrc_o` carries the code latched at the start. A request stays valid and stable until it is accepted, and a reading is taken only while `meas_res_ready_o` is high.
- R4: Call the pin 1 reading A, the pin 2 reading B, and the thresholds LO (`thr_lo_i`) and HI (`thr_hi_i`). If A>=HI and B>=HI, the routing outputs keep their values and no interrupt is raised.
- R5: Otherwise, if (B>A>LO and A<HI) or (B>LO>A), the block sets `mic_pin_o`=2 (pin 2), `gnd_pin_o`=1 (pin 1) and `sense_sel_o`=1 (ground-sense 1), and it raises an interrupt.
- R6: Otherwise, if (A>B>LO and B<HI) or (A>LO>B), the block sets `mic_pin_o`=1, `gnd_pin_o`=2 and `sense_sel_o`=2, and it raises an interrupt.
- R7: Otherwise, if LO>=A and LO>=B, the block sets `gnd_pin_o`=1, `sense_sel_o`=1 and `mic_pin_o`=0 (open), and it raises no interrupt.
- R8: A reading pair that matches none of R4 to R7 leaves the routing unchanged and raises no interrupt. Routing outputs change only at the end of a run.
- R9: While `busy_o` is high, `lr_on_o` and `aux_on_o` are both low. At the end of a run, `busy_o` falls and for one cycle `lr_on_o` is high with `aux_on_o` still low. On the next cycle `aux_on_o` goes high.
- R10: `irq_o` is a single-cycle pulse, given in the cycle in which `busy_o` falls. It sets `irq_flag_o` on the next cycle. `irq_clr_i` clears the flag, but a set in the same cycle as a clear wins.
- R11: After reset, `busy_o`, `err_o`, `irq_o`, `irq_flag_o`, `aux_on_o` and `meas_cmd_valid_o` are low, and `mic_pin_o`, `gnd_pin_o` and `sense_sel_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | Detection function enable |
| req_right_i | input | 1 | Right audio switch requested on |
| req_left_i | input | 1 | Left audio switch requested on |
| req_agnd_i | input | 1 | Audio ground switch requested on |
| start_i | input | 1 | Start a detection run |
| isrc_code_i | input | 4 | Current source code, 100 uA per step, 0 invalid |
| thr_lo_i | input | MEAS_W | Low threshold |
| thr_hi_i | input | MEAS_W | High threshold |
| irq_clr_i | input | 1 | Clear strobe for the sticky interrupt flag |
| meas_cmd_valid_o | output | 1 | Measurement request valid |
| meas_cmd_ready_i | input | 1 | Measurement request accepted |
| meas_cmd_pin_o | output | 1 | Pin to measure, 0 = pin 1, 1 = pin 2 |
| meas_cmd_isrc_o | output | 4 | Current source code for the measurement |
| meas_res_valid_i | input | 1 | Reading valid |
| meas_res_ready_o | output | 1 | Block can take a reading |
| meas_res_data_i | input | MEAS_W | Reading |
| mic_pin_o | output | 2 | Microphone route: 0 open, 1 pin 1, 2 pin 2 |
| gnd_pin_o | output | 2 | Audio ground route: 0 open, 1 pin 1, 2 pin 2 |
| sense_sel_o | output | 2 | Sense route: 0 none, 1 ground-sense 1, 2 ground-sense 2 |
| lr_on_o | output | 1 | Left/right audio switches enabled |
| aux_on_o | output | 1 | Microphone/sense/ground switches enabled |
| busy_o | output | 1 | Detection run in progress |
| err_o | output | 1 | Last start attempt had an invalid code |
| irq_o | output | 1 | Orientation-found pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
Two events can land on the same clock edge: the interrupt pulse at the end of a run, and a clear strobe from software. To provoke this, the bench raises `irq_clr_i` at exactly the cycle in which `busy_o` falls for a run that finds an orientation. The strobe therefore meets `irq_o` at the same edge, and the flag must read high afterwards. A later lone strobe must then bring the flag low. The bench also makes the pin 1 request stall while a stray reading is offered on the result side. This checks that nothing is taken while the block is not ready.

// File: rtl/hsdet_pkg.sv
package hsdet_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_RES, ST_DECIDE, ST_LR
  } hsdet_state_e;

  typedef enum logic [2:0] {
    VD_NONE, VD_HOLD, VD_MIC_P2, VD_MIC_P1, VD_SINGLE
  } hsdet_verdict_e;

  localparam logic [1:0] PIN_OPEN = 2'd0;
  localparam logic [1:0] PIN_ONE  = 2'd1;
  localparam logic [1:0] PIN_TWO  = 2'd2;
endpackage

// File: rtl/hsdet_judge.sv
module hsdet_judge
  import hsdet_pkg::*;
#(
  parameter int MEAS_W = 10
) (
  input  logic [MEAS_W-1:0] rd_a_i,
  input  logic [MEAS_W-1:0] rd_b_i,
  input  logic [MEAS_W-1:0] lo_i,
  input  logic [MEAS_W-1:0] hi_i,
  output hsdet_verdict_e    verdict_o
);
  logic both_high, mic_on_two, mic_on_one, both_low;

  always_comb begin
    both_high  = (rd_a_i >= hi_i) && (rd_b_i >= hi_i);
    mic_on_two = ((rd_b_i > rd_a_i) && (rd_a_i > lo_i) && (rd_a_i < hi_i)) ||
                 ((rd_b_i > lo_i) && (lo_i > rd_a_i));
    mic_on_one = ((rd_a_i > rd_b_i) && (rd_b_i > lo_i) && (rd_b_i < hi_i)) ||
                 ((rd_a_i > lo_i) && (lo_i > rd_b_i));
    both_low   = (lo_i >= rd_a_i) && (lo_i >= rd_b_i);
    if (both_high)       verdict_o = VD_HOLD;
    else if (mic_on_two) verdict_o = VD_MIC_P2;
    else if (mic_on_one) verdict_o = VD_MIC_P1;
    else if (both_low)   verdict_o = VD_SINGLE;
    else                 verdict_o = VD_NONE;
  end
endmodule

// File: rtl/hsdet_seq.sv
module hsdet_seq
  import hsdet_pkg::*;
#(
  parameter int MEAS_W = 10,
  parameter int CODE_W = 4,
  parameter int NPIN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              cmd_ready_i,
  input  logic              res_valid_i,
  input  logic [MEAS_W-1:0] res_data_i,
  output logic              cmd_valid_o,
  output logic              cmd_pin_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic              res_ready_o,
  output logic [MEAS_W-1:0] rd_a_o,
  output logic [MEAS_W-1:0] rd_b_o,
  output logic              decide_o,
  output logic              lr_phase_o,
  output logic              idle_o,
  output logic              busy_o,
  output logic              aux_en_o,
  output logic              err_o
);
  localparam int PW = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam logic [PW-1:0] LAST_PIN = PW'(NPIN - 1);

  hsdet_state_e      st_q;
  logic [PW-1:0]     pin_q;
  logic [CODE_W-1:0] code_q;
  logic [MEAS_W-1:0] rd_q [NPIN];
  logic              err_q, aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pin_q  <= '0;
      code_q <= '0;
      err_q  <= 1'b0;
      aux_q  <= 1'b0;
      for (int i = 0; i < NPIN; i++) rd_q[i] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          if (code_i == '0) err_q <= 1'b1;
          else begin
            err_q  <= 1'b0;
            aux_q  <= 1'b0;
            code_q <= code_i;
            pin_q  <= '0;
            st_q   <= ST_CMD;
          end
        end
        ST_CMD: if (cmd_ready_i) st_q <= ST_RES;
        ST_RES: if (res_valid_i) begin
          rd_q[pin_q] <= res_data_i;
          if (pin_q == LAST_PIN) st_q <= ST_DECIDE;
          else begin
            pin_q <= pin_q + 1'b1;
            st_q  <= ST_CMD;
          end
        end
        ST_DECIDE: st_q <= ST_LR;
        ST_LR: begin
          aux_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == ST_CMD);
  assign cmd_pin_o   = pin_q[0];
  assign cmd_code_o  = code_q;
  assign res_ready_o = (st_q == ST_RES);
  assign rd_a_o      = rd_q[0];
  assign rd_b_o      = rd_q[NPIN-1];
  assign decide_o    = (st_q == ST_DECIDE);
  assign lr_phase_o  = (st_q == ST_LR);
  assign idle_o      = (st_q == ST_IDLE);
  assign busy_o      = (st_q == ST_CMD) || (st_q == ST_RES) || (st_q == ST_DECIDE);
  assign aux_en_o    = aux_q;
  assign err_o       = err_q;
endmodule

// File: rtl/hsdet_route.sv
module hsdet_route
  import hsdet_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           decide_i,
  input  hsdet_verdict_e verdict_i,
  input  logic           irq_clr_i,
  output logic [1:0]     mic_o,
  output logic [1:0]     gnd_o,
  output logic [1:0]     sense_o,
  output logic           irq_o,
  output logic           flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mic_o   <= PIN_OPEN;
      gnd_o   <= PIN_OPEN;
      sense_o <= PIN_OPEN;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (decide_i) begin
        case (verdict_i)
          VD_MIC_P2: begin
            mic_o <= PIN_TWO; gnd_o <= PIN_ONE; sense_o <= PIN_ONE; irq_o <= 1'b1;
          end
          VD_MIC_P1: begin
            mic_o <= PIN_ONE; gnd_o <= PIN_TWO; sense_o <= PIN_TWO; irq_o <= 1'b1;
          end
          VD_SINGLE: begin
            mic_o <= PIN_OPEN; gnd_o <= PIN_ONE; sense_o <= PIN_ONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_o <= 1'b0;
    else if (irq_o)     flag_o <= 1'b1;
    else if (irq_clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/hsdet_top.sv
module hsdet_top
  import hsdet_pkg::*;
#(
  parameter int MEAS_W = 10,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en_i,
  input  logic              req_right_i,
  input  logic              req_left_i,
  input  logic              req_agnd_i,
  input  logic              start_i,
  input  logic [CODE_W-1:0] isrc_code_i,
  input  logic [MEAS_W-1:0] thr_lo_i,
  input  logic [MEAS_W-1:0] thr_hi_i,
  input  logic              irq_clr_i,
  output logic              meas_cmd_valid_o,
  input  logic              meas_cmd_ready_i,
  output logic              meas_cmd_pin_o,
  output logic [CODE_W-1:0] meas_cmd_isrc_o,
  input  logic              meas_res_valid_i,
  output logic              meas_res_ready_o,
  input  logic [MEAS_W-1:0] meas_res_data_i,
  output logic [1:0]        mic_pin_o,
  output logic [1:0]        gnd_pin_o,
  output logic [1:0]        sense_sel_o,
  output logic              lr_on_o,
  output logic              aux_on_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              irq_flag_o
);
  logic              go, decide, lr_phase, idle, aux_en;
  logic [MEAS_W-1:0] rd_a, rd_b;
  hsdet_verdict_e    verdict;

  assign go = start_i && det_en_i && req_right_i && req_left_i && req_agnd_i;

  hsdet_seq #(.MEAS_W(MEAS_W), .CODE_W(CODE_W), .NPIN(2)) u_seq (
    .clk, .rst_n, .go_i(go), .code_i(isrc_code_i),
    .cmd_ready_i(meas_cmd_ready_i), .res_valid_i(meas_res_valid_i),
    .res_data_i(meas_res_data_i), .cmd_valid_o(meas_cmd_valid_o),
    .cmd_pin_o(meas_cmd_pin_o), .cmd_code_o(meas_cmd_isrc_o),
    .res_ready_o(meas_res_ready_o), .rd_a_o(rd_a), .rd_b_o(rd_b),
    .decide_o(decide), .lr_phase_o(lr_phase), .idle_o(idle),
    .busy_o(busy_o), .aux_en_o(aux_en), .err_o(err_o)
  );

  hsdet_judge #(.MEAS_W(MEAS_W)) u_judge (
    .rd_a_i(rd_a), .rd_b_i(rd_b), .lo_i(thr_lo_i), .hi_i(thr_hi_i),
    .verdict_o(verdict)
  );

  hsdet_route u_route (
    .clk, .rst_n, .decide_i(decide), .verdict_i(verdict), .irq_clr_i(irq_clr_i),
    .mic_o(mic_pin_o), .gnd_o(gnd_pin_o), .sense_o(sense_sel_o),
    .irq_o(irq_o), .flag_o(irq_flag_o)
  );

  assign lr_on_o  = req_right_i && req_left_i && (lr_phase || idle);
  assign aux_on_o = aux_en && idle;
endmodule

// File: rtl/hsdet_chk.sv
module hsdet_chk #(
  parameter int MEAS_W = 10,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_en_i,
  input logic              req_right_i,
  input logic              req_left_i,
  input logic              req_agnd_i,
  input logic              start_i,
  input logic [CODE_W-1:0] isrc_code_i,
  input logic              meas_cmd_valid_o,
  input logic              meas_cmd_ready_i,
  input logic              meas_cmd_pin_o,
  input logic [CODE_W-1:0] meas_cmd_isrc_o,
  input logic [1:0]        mic_pin_o,
  input logic [1:0]        gnd_pin_o,
  input logic [1:0]        sense_sel_o,
  input logic              lr_on_o,
  input logic              aux_on_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              irq_o,
  input logic              irq_flag_o
);
  // R1
  run_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i && det_en_i && req_right_i && req_left_i &&
                            req_agnd_i && (isrc_code_i != '0)));
  // R2
  err_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o);
  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_cmd_valid_o && !meas_cmd_ready_i |=>
      meas_cmd_valid_o && $stable(meas_cmd_pin_o) && $stable(meas_cmd_isrc_o));
  // R8
  route_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(mic_pin_o) && $stable(gnd_pin_o) && $stable(sense_sel_o));
  // R9
  switches_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !lr_on_o && !aux_on_o);
  // R9
  aux_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !aux_on_o);
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o && irq_flag_o);
endmodule

bind hsdet_top hsdet_chk #(.MEAS_W(MEAS_W), .CODE_W(CODE_W)) u_chk (
  .clk, .rst_n, .det_en_i, .req_right_i, .req_left_i, .req_agnd_i, .start_i,
  .isrc_code_i, .meas_cmd_valid_o, .meas_cmd_ready_i, .meas_cmd_pin_o,
  .meas_cmd_isrc_o, .mic_pin_o, .gnd_pin_o, .sense_sel_o, .lr_on_o, .aux_on_o,
  .busy_o, .err_o, .irq_o, .irq_flag_o
);

// File: tb/hsdet_top_tb_top.sv
module hsdet_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 0, rst_n = 0;
  logic det_en = 0, req_r = 0, req_l = 0, req_g = 0, start = 0, irq_clr = 0;
  logic [3:0] code = 4'd7;
  logic [W-1:0] lo = 10'd100, hi = 10'd800;
  logic cmd_ready = 0, res_valid = 0;
  logic [W-1:0] res_data = '0;
  logic cmd_valid, cmd_pin, res_ready, lr_on, aux_on, busy, err, irq, flag;
  logic [3:0] cmd_isrc;
  logic [1:0] mic, gnd, sense;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsdet_top #(.MEAS_W(W), .CODE_W(4)) dut_i (
    .clk, .rst_n, .det_en_i(det_en), .req_right_i(req_r), .req_left_i(req_l),
    .req_agnd_i(req_g), .start_i(start), .isrc_code_i(code), .thr_lo_i(lo),
    .thr_hi_i(hi), .irq_clr_i(irq_clr), .meas_cmd_valid_o(cmd_valid),
    .meas_cmd_ready_i(cmd_ready), .meas_cmd_pin_o(cmd_pin),
    .meas_cmd_isrc_o(cmd_isrc), .meas_res_valid_i(res_valid),
    .meas_res_ready_o(res_ready), .meas_res_data_i(res_data),
    .mic_pin_o(mic), .gnd_pin_o(gnd), .sense_sel_o(sense), .lr_on_o(lr_on),
    .aux_on_o(aux_on), .busy_o(busy), .err_o(err), .irq_o(irq),
    .irq_flag_o(flag)
  );

  typedef struct {
    int mic; int gnd; int sense; int irq; string tag;
  } exp_t;

  exp_t sbq[$];
  int total = 0, bad = 0;
  int e_mic = 0, e_gnd = 0, e_sense = 0;
  bit clr_on_irq = 0, aux_pend = 0, aux_irq = 0, prev_busy = 0;
  string aux_tag;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of the ordered rules, taken from the requirements
  function automatic exp_t model(input int a, input int b, input string tag);
    exp_t e;
    int l = int'(lo), h = int'(hi);
    e.irq = 0; e.tag = tag;
    if (a >= h && b >= h) ;
    else if ((b > a && a > l && a < h) || (b > l && l > a)) begin
      e_mic = 2; e_gnd = 1; e_sense = 1; e.irq = 1;
    end else if ((a > b && b > l && b < h) || (a > l && l > b)) begin
      e_mic = 1; e_gnd = 2; e_sense = 2; e.irq = 1;
    end else if (l >= a && l >= b) begin
      e_mic = 0; e_gnd = 1; e_sense = 1;
    end
    e.mic = e_mic; e.gnd = e_gnd; e.sense = e_sense;
    return e;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && (lr_on || aux_on)) chk(0, "R9 switches on while busy", 1, 0);
      if (aux_pend) begin
        aux_pend = 0;
        chk(aux_on == 1'b1, {"R9 aux after lr ", aux_tag}, aux_on, 1);
        if (aux_irq) chk(flag == 1'b1, {"R10 flag set ", aux_tag}, flag, 1);
        irq_clr = 0;
      end
      if (prev_busy && !busy) begin
        exp_t e;
        if (sbq.size() == 0) chk(0, "R8 unexpected run end", 1, 0);
        else begin
          e = sbq.pop_front();
          chk(int'(mic) == e.mic, {e.tag, " mic route"}, int'(mic), e.mic);
          chk(int'(gnd) == e.gnd, {e.tag, " gnd route"}, int'(gnd), e.gnd);
          chk(int'(sense) == e.sense, {e.tag, " sense route"}, int'(sense), e.sense);
          chk(int'(irq) == e.irq, {e.tag, " R10 irq pulse"}, int'(irq), e.irq);
          chk(lr_on && !aux_on, {e.tag, " R9 lr first"}, {lr_on, aux_on}, 2);
          aux_pend = 1; aux_irq = e.irq[0]; aux_tag = e.tag;
          if (clr_on_irq) irq_clr = 1;
        end
      end
      prev_busy = busy;
    end
  end

  task automatic push_res(input logic [W-1:0] v);
    res_data = v; res_valid = 1;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic serve_cmd(input bit pin, input bit stall, input logic [W-1:0] v);
    while (!cmd_valid) @(negedge clk);
    chk(cmd_pin == pin, "R3 request order", cmd_pin, pin);
    chk(cmd_isrc == code, "R3 request code", cmd_isrc, code);
    if (stall) begin
      res_valid = 1; res_data = 10'd1023;
      repeat (2) @(negedge clk);
      chk(cmd_valid && cmd_pin == pin, "R3 request held", cmd_valid, 1);
      chk(res_ready == 1'b0, "R3 no ready before request", res_ready, 0);
    end
    cmd_ready = 1; res_data = v;
    @(negedge clk);
    cmd_ready = 0;
    push_res(v);
  endtask

  task automatic run(input int a, input int b, input string tag, input bit stall);
    sbq.push_back(model(a, b, tag));
    start = 1;
    @(negedge clk);
    start = 0;
    serve_cmd(0, stall, W'(a));
    serve_cmd(1, 0, W'(b));
    while (sbq.size() != 0 || aux_pend) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(busy == 0 && err == 0 && irq == 0 && flag == 0, "R11 reset flags", {busy, err, irq, flag}, 0);
    chk(mic == 0 && gnd == 0 && sense == 0, "R11 reset routes", {mic, gnd, sense}, 0);
    chk(cmd_valid == 0 && aux_on == 0, "R11 reset handshake", {cmd_valid, aux_on}, 0);
    // R1: disabled function
    req_r = 1; req_l = 1; req_g = 1;
    start = 1; @(negedge clk); start = 0; repeat (3) @(negedge clk);
    chk(busy == 0 && cmd_valid == 0, "R1 disabled no run", {busy, cmd_valid}, 0);
    // R1: ground switch not requested
    det_en = 1; req_g = 0;
    start = 1; @(negedge clk); start = 0; repeat (3) @(negedge clk);
    chk(busy == 0 && cmd_valid == 0, "R1 agnd not requested", {busy, cmd_valid}, 0);
    req_g = 1;
    // R2: invalid code
    code = 4'd0;
    start = 1; @(negedge clk); start = 0; repeat (2) @(negedge clk);
    chk(err == 1 && busy == 0 && cmd_valid == 0, "R2 invalid code", {err, busy, cmd_valid}, 4);
    code = 4'd7;
    run(300, 500, "R5", 1);
    chk(err == 0, "R2 err cleared by run", err, 0);
    run(50, 900, "R5", 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(flag == 0, "R10 flag cleared", flag, 0);
    code = 4'd15;
    run(500, 300, "R6", 0);
    run(900, 50, "R6", 0);
    run(850, 900, "R4", 0);
    run(800, 800, "R4", 0);
    run(300, 300, "R8", 0);
    run(100, 500, "R8", 0);
    run(799, 800, "R5", 0);
    run(50, 80, "R7", 0);
    run(100, 100, "R7", 0);
    clr_on_irq = 1;
    run(500, 300, "R10", 0);
    clr_on_irq = 0;
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(flag == 0, "R10 clear after coincidence", flag, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule